// File: doc/BRIEF.md
# Programmable Color Combiner Stage

A single link in a chain of per-fragment color combiners. Each fragment arrives as a bundle of general color registers, each holding red, green, blue and alpha channels, plus a configuration word that travels with it. The stage reads four operands, A to D, out of that bundle. Each operand passes through its own input mapping. Two operand pairs are then reduced, either per channel or as a three-term dot product. The two pair results are merged, then shifted and offset, then saturated. The result is written back into the bundle that the next stage in the chain reads.

The color part and the alpha part are independent datapaths with separate operand choices, operations, scale, bias and destination register. Channels are signed fixed-point numbers in which +1.0 is `2^FRAC`. Fragments move through a two-register pipeline with a valid/ready handshake on both sides. The configuration is captured together with the fragment, so it may change freely between fragments.

Top module: `cmb_stage`

## Requirements
- R1: After reset is released and before any fragment is accepted, `valid_o` is 0 and `ready_o` is 1.
- R2: The register bundle holds 4 registers of 4 channels, each CH_W=10 bits signed, with +1.0 = 256. Register r, channel c (0 red, 1 green, 2 blue, 3 alpha) occupies bits `[(4r+c)*10 +: 10]`. Every channel not written by R8 leaves the stage unchanged.
- R3: Each operand is mapped by a 2-bit code: 0 passes x, 1 gives 256−x, 2 gives 2x−256, 3 gives −x. The mapped value is clamped to [−256, 256]. In the configuration word, color operand k (A=0..D=3) has its map code at bits [4k+1:4k] and its source register at [4k+3:4k+2].
- R4: Config bit 36 (for A,B) and bit 37 (for C,D) choose the pair reduction. With 0, the pair result is the per-channel product `floor(x*y/256)`. With 1, the pair result is `floor((x0y0+x1y1+x2y2)/256)` placed on all three color channels.
- R5: Config bit 38 (color) and bit 39 (alpha) choose the merge. With 0, the two pair results are added. With 1, the merge takes CD when the raw incoming alpha of register 0 is negative, and AB otherwise.
- R6: Alpha operand k sits at bits 16+5k and up: map code in the low 2 bits, source register in the next 2 bits, and a fifth bit that takes the source's blue channel instead of its alpha. The alpha pair results are always `floor(x*y/256)`.
- R7: Each part's merged value is reduced by 128 when its bias bit is set (bit 44 color, bit 45 alpha). It is then scaled by a 2-bit code (bits [41:40] color, [43:42] alpha): 0 gives x1, 1 gives x2, 2 gives x4, 3 gives floor(x/2). Finally it is saturated to [−256, 256].
- R8: The color result replaces red, green and blue of the register named by bits [47:46]. The alpha result replaces the alpha of the register named by bits [49:48]. Both writes apply when the two fields name the same register.
- R9: A fragment accepted on an edge appears on `valid_o`/`regs_o` after the second edge when `ready_i` is high. `valid_o` is high exactly while a processed fragment is waiting at the output.
- R10: While `valid_o` is high and `ready_i` is low, `regs_o` holds steady. `ready_o` is low only when both pipeline registers are full and `ready_i` is low. No fragment is lost or duplicated. Each fragment uses the configuration present when it was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Incoming fragment present |
| ready_o | output | 1 | Stage can take a fragment |
| cfg_i | input | 50 | Per-fragment configuration word |
| regs_i | input | 160 | Incoming register bundle |
| valid_o | output | 1 | Outgoing fragment present |
| ready_i | input | 1 | Next stage can take a fragment |
| regs_o | output | 160 | Updated register bundle |

## Verification
The hardest situation to reach is a full pipeline that stalls while the configuration and register inputs are being changed under it. That is the only case where a design that reads live configuration instead of latched configuration goes wrong. The stimulus withholds `ready_i` at random for long stretches. It drives random configuration and register garbage on every idle input cycle, so any fragment still depending on the port values would miscompute. The clamp and saturation edges are reached on purpose: inputs at the most negative and most positive codes, combined with the doubling map and the x4 scale.

// File: rtl/cmb_pkg.sv
package cmb_pkg;
  parameter int unsigned CMB_SEL_W = 2;
  localparam int unsigned CMB_NREG = 1 << CMB_SEL_W;
  localparam int unsigned CMB_NCH  = 4;

  typedef logic [CMB_SEL_W-1:0] reg_sel_t;

  typedef enum logic [1:0] {MAP_ID, MAP_INV, MAP_EXP, MAP_NEG} map_e;
  typedef enum logic       {PAIR_MUL, PAIR_DOT} pair_e;
  typedef enum logic       {MRG_SUM, MRG_MUX} merge_e;
  typedef enum logic [1:0] {SC_X1, SC_X2, SC_X4, SC_HALF} scale_e;

  typedef struct packed {
    reg_sel_t sel;
    map_e     mode;
  } rgb_opnd_t;

  typedef struct packed {
    logic     blue;
    reg_sel_t sel;
    map_e     mode;
  } a_opnd_t;

  // declared MSB first; operand A sits at the lowest bits
  typedef struct packed {
    reg_sel_t        a_dst;
    reg_sel_t        rgb_dst;
    logic            a_bias;
    logic            rgb_bias;
    scale_e          a_scale;
    scale_e          rgb_scale;
    merge_e          op4;
    merge_e          op3;
    pair_e           op2;
    pair_e           op1;
    a_opnd_t   [3:0] a_in;
    rgb_opnd_t [3:0] rgb_in;
  } cmb_cfg_t;
endpackage

// File: rtl/cmb_operand_map.sv
module cmb_operand_map import cmb_pkg::*; #(
  parameter int unsigned CH_W = 10,
  parameter int unsigned FRAC = 8
) (
  input  logic [CH_W-1:0] x_i,
  input  map_e            mode_i,
  output logic [CH_W-1:0] y_o
);
  localparam int unsigned W = CH_W + 2;
  localparam logic signed [W-1:0] POS1 = W'(1 << FRAC);
  localparam logic signed [W-1:0] NEG1 = -POS1;

  logic signed [W-1:0] xe, t;

  assign xe = W'($signed(x_i));

  always_comb begin
    unique case (mode_i)
      MAP_ID:  t = xe;
      MAP_INV: t = POS1 - xe;
      MAP_EXP: t = (xe <<< 1) - POS1;
      default: t = -xe;
    endcase
  end

  always_comb begin
    if (t > POS1)      y_o = POS1[CH_W-1:0];
    else if (t < NEG1) y_o = NEG1[CH_W-1:0];
    else               y_o = t[CH_W-1:0];
  end
endmodule

// File: rtl/cmb_scale_sat.sv
module cmb_scale_sat import cmb_pkg::*; #(
  parameter int unsigned IW   = 15,
  parameter int unsigned CH_W = 10,
  parameter int unsigned FRAC = 8
) (
  input  logic [IW-1:0]   x_i,
  input  scale_e          scale_i,
  input  logic            bias_i,
  output logic [CH_W-1:0] y_o
);
  localparam int unsigned W = IW + 3;
  localparam logic signed [W-1:0] POS1 = W'(1 << FRAC);
  localparam logic signed [W-1:0] NEG1 = -POS1;
  localparam logic signed [W-1:0] HALF = W'(1 << (FRAC - 1));

  logic signed [W-1:0] xb, xs;

  assign xb = W'($signed(x_i)) - (bias_i ? HALF : '0);

  always_comb begin
    unique case (scale_i)
      SC_X1:   xs = xb;
      SC_X2:   xs = xb <<< 1;
      SC_X4:   xs = xb <<< 2;
      default: xs = xb >>> 1;
    endcase
  end

  always_comb begin
    if (xs > POS1)      y_o = POS1[CH_W-1:0];
    else if (xs < NEG1) y_o = NEG1[CH_W-1:0];
    else                y_o = xs[CH_W-1:0];
  end
endmodule

// File: rtl/cmb_stage.sv
module cmb_stage import cmb_pkg::*; #(
  parameter int unsigned CH_W      = 10,
  parameter int unsigned FRAC      = 8,
  parameter int unsigned SPARE_REG = 0,
  localparam int unsigned BUS_W    = CMB_NREG * CMB_NCH * CH_W,
  localparam int unsigned CFG_W    = $bits(cmb_cfg_t)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  output logic             ready_o,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic [BUS_W-1:0] regs_i,
  output logic             valid_o,
  input  logic             ready_i,
  output logic [BUS_W-1:0] regs_o
);
  localparam int unsigned NCH  = CMB_NCH;
  localparam int unsigned NREG = CMB_NREG;
  localparam int unsigned PW   = 2 * CH_W;
  localparam int unsigned DW   = PW + 2;
  localparam int unsigned RW   = DW - FRAC;
  localparam int unsigned MW   = RW + 1;

  cmb_cfg_t cfg_in;
  assign cfg_in = cmb_cfg_t'(cfg_i);

  logic [CH_W-1:0] in_ch [NREG][NCH];
  for (genvar r = 0; r < NREG; r++) begin : g_unpack_r
    for (genvar c = 0; c < NCH; c++) begin : g_unpack_c
      assign in_ch[r][c] = regs_i[(r*NCH+c)*CH_W +: CH_W];
    end
  end

  // operand mapping, four color operands and four alpha operands
  logic [CH_W-1:0] opr [4][3];
  logic [CH_W-1:0] opa [4];
  for (genvar k = 0; k < 4; k++) begin : g_opnd
    for (genvar c = 0; c < 3; c++) begin : g_ch
      cmb_operand_map #(.CH_W(CH_W), .FRAC(FRAC)) u_rmap (
        .x_i    (in_ch[cfg_in.rgb_in[k].sel][c]),
        .mode_i (cfg_in.rgb_in[k].mode),
        .y_o    (opr[k][c])
      );
    end
    logic [CH_W-1:0] a_src;
    assign a_src = cfg_in.a_in[k].blue ? in_ch[cfg_in.a_in[k].sel][2]
                                       : in_ch[cfg_in.a_in[k].sel][3];
    cmb_operand_map #(.CH_W(CH_W), .FRAC(FRAC)) u_amap (
      .x_i    (a_src),
      .mode_i (cfg_in.a_in[k].mode),
      .y_o    (opa[k])
    );
  end

  // pair reductions
  logic signed [PW-1:0] pab [3], pcd [3];
  logic signed [PW-1:0] paa, pac;
  logic signed [DW-1:0] dab, dcd;
  logic signed [RW-1:0] ab_n [3], cd_n [3];
  logic signed [RW-1:0] aab_n, acd_n;

  always_comb begin
    for (int c = 0; c < 3; c++) begin
      pab[c] = PW'($signed(opr[0][c])) * PW'($signed(opr[1][c]));
      pcd[c] = PW'($signed(opr[2][c])) * PW'($signed(opr[3][c]));
    end
    dab = DW'(pab[0]) + DW'(pab[1]) + DW'(pab[2]);
    dcd = DW'(pcd[0]) + DW'(pcd[1]) + DW'(pcd[2]);
    for (int c = 0; c < 3; c++) begin
      ab_n[c] = (cfg_in.op1 == PAIR_DOT) ? RW'(dab >>> FRAC) : RW'(DW'(pab[c]) >>> FRAC);
      cd_n[c] = (cfg_in.op2 == PAIR_DOT) ? RW'(dcd >>> FRAC) : RW'(DW'(pcd[c]) >>> FRAC);
    end
    paa   = PW'($signed(opa[0])) * PW'($signed(opa[1]));
    pac   = PW'($signed(opa[2])) * PW'($signed(opa[3]));
    aab_n = RW'(DW'(paa) >>> FRAC);
    acd_n = RW'(DW'(pac) >>> FRAC);
  end

  // pipeline handshake
  logic s1_v, s2_v, s1_rdy, s2_rdy;
  assign s2_rdy  = !s2_v || ready_i;
  assign s1_rdy  = !s1_v || s2_rdy;
  assign ready_o = s1_rdy;
  assign valid_o = s2_v;

  cmb_cfg_t             s1_cfg;
  logic [BUS_W-1:0]     s1_regs, s2_regs, wb;
  logic signed [RW-1:0] s1_ab [3], s1_cd [3];
  logic signed [RW-1:0] s1_aab, s1_acd;
  logic                 s1_neg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v    <= 1'b0;
      s1_cfg  <= '0;
      s1_regs <= '0;
      s1_aab  <= '0;
      s1_acd  <= '0;
      s1_neg  <= 1'b0;
      for (int c = 0; c < 3; c++) begin
        s1_ab[c] <= '0;
        s1_cd[c] <= '0;
      end
    end else if (s1_rdy) begin
      s1_v <= valid_i;
      if (valid_i) begin
        s1_cfg  <= cfg_in;
        s1_regs <= regs_i;
        s1_aab  <= aab_n;
        s1_acd  <= acd_n;
        s1_neg  <= in_ch[SPARE_REG][3][CH_W-1];
        for (int c = 0; c < 3; c++) begin
          s1_ab[c] <= ab_n[c];
          s1_cd[c] <= cd_n[c];
        end
      end
    end
  end

  // merge, scale/bias, writeback
  logic signed [MW-1:0] mrg [3];
  logic signed [MW-1:0] amrg;

  always_comb begin
    for (int c = 0; c < 3; c++) begin
      if (s1_cfg.op3 == MRG_MUX) mrg[c] = s1_neg ? MW'(s1_cd[c]) : MW'(s1_ab[c]);
      else                       mrg[c] = MW'(s1_ab[c]) + MW'(s1_cd[c]);
    end
    if (s1_cfg.op4 == MRG_MUX) amrg = s1_neg ? MW'(s1_acd) : MW'(s1_aab);
    else                       amrg = MW'(s1_aab) + MW'(s1_acd);
  end

  logic [2:0][CH_W-1:0] rgb_res;
  logic [CH_W-1:0]      a_res;

  for (genvar c = 0; c < 3; c++) begin : g_rsb
    cmb_scale_sat #(.IW(MW), .CH_W(CH_W), .FRAC(FRAC)) u_rsb (
      .x_i     (mrg[c]),
      .scale_i (s1_cfg.rgb_scale),
      .bias_i  (s1_cfg.rgb_bias),
      .y_o     (rgb_res[c])
    );
  end

  cmb_scale_sat #(.IW(MW), .CH_W(CH_W), .FRAC(FRAC)) u_asb (
    .x_i     (amrg),
    .scale_i (s1_cfg.a_scale),
    .bias_i  (s1_cfg.a_bias),
    .y_o     (a_res)
  );

  always_comb begin
    wb = s1_regs;
    for (int c = 0; c < 3; c++)
      wb[(int'(s1_cfg.rgb_dst)*NCH + c)*CH_W +: CH_W] = rgb_res[c];
    wb[(int'(s1_cfg.a_dst)*NCH + 3)*CH_W +: CH_W] = a_res;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_v    <= 1'b0;
      s2_regs <= '0;
    end else if (s2_rdy) begin
      s2_v <= s1_v;
      if (s1_v) s2_regs <= wb;
    end
  end

  assign regs_o = s2_regs;
endmodule

// File: rtl/cmb_stage_chk.sv
module cmb_stage_chk #(
  parameter int unsigned CH_W  = 10,
  parameter int unsigned FRAC  = 8,
  parameter int unsigned BUS_W = 160
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 valid_i,
  input logic                 ready_o,
  input logic                 valid_o,
  input logic                 ready_i,
  input logic [BUS_W-1:0]     regs_o,
  input logic                 res_v,
  input logic [2:0][CH_W-1:0] rgb_res,
  input logic [CH_W-1:0]      a_res
);
  localparam logic signed [CH_W-1:0] POS1 = CH_W'(1 << FRAC);
  localparam logic signed [CH_W-1:0] NEG1 = -POS1;

  // R1
  empty_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ready_o);

  // R10
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(regs_o));

  // R9
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) ##1 ready_i |=> valid_o);

  // R7
  for (genvar c = 0; c < 3; c++) begin : g_sat
    rgb_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      res_v |-> ($signed(rgb_res[c]) <= POS1) && ($signed(rgb_res[c]) >= NEG1));
  end

  // R7
  a_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_v |-> ($signed(a_res) <= POS1) && ($signed(a_res) >= NEG1));
endmodule

bind cmb_stage cmb_stage_chk #(.CH_W(CH_W), .FRAC(FRAC), .BUS_W(BUS_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .ready_o (ready_o),
  .valid_o (valid_o),
  .ready_i (ready_i),
  .regs_o  (regs_o),
  .res_v   (s1_v),
  .rgb_res (rgb_res),
  .a_res   (a_res)
);

// File: tb/tb_cmb_stage.sv
module tb_cmb_stage;
  localparam int ONE   = 256;
  localparam int BUS_W = 160;
  localparam int CFG_W = 50;

  typedef int bundle_t [4][4];
  typedef struct {
    int rsel[4]; int rmap[4];
    int asel[4]; int amap[4]; int ablue[4];
    int op1, op2, op3, op4, rsc, asc, rbias, abias, rdst, adst;
  } tcfg_t;

  logic clk = 1'b0, rst_ni = 1'b0, valid_i = 1'b0, ready_i = 1'b0;
  logic ready_o, valid_o;
  logic [CFG_W-1:0] cfg_i = '0;
  logic [BUS_W-1:0] regs_i = '0, regs_o;

  always #10 clk = ~clk; // 50 MHz with 1 ns units

  cmb_stage dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .ready_o(ready_o),
    .cfg_i(cfg_i), .regs_i(regs_i), .valid_o(valid_o), .ready_i(ready_i),
    .regs_o(regs_o)
  );

  int n_vec = 0, n_bad = 0;

  function automatic logic [BUS_W-1:0] pack_regs(bundle_t r);
    logic [BUS_W-1:0] v = '0;
    for (int i = 0; i < 4; i++)
      for (int c = 0; c < 4; c++) v[(4*i+c)*10 +: 10] = 10'(r[i][c]);
    return v;
  endfunction

  function automatic logic [CFG_W-1:0] pack_cfg(tcfg_t c);
    logic [CFG_W-1:0] v = '0;
    for (int k = 0; k < 4; k++) begin
      v[4*k +: 2]      = 2'(c.rmap[k]);
      v[4*k+2 +: 2]    = 2'(c.rsel[k]);
      v[16+5*k +: 2]   = 2'(c.amap[k]);
      v[16+5*k+2 +: 2] = 2'(c.asel[k]);
      v[16+5*k+4]      = c.ablue[k][0];
    end
    v[36] = c.op1[0]; v[37] = c.op2[0]; v[38] = c.op3[0]; v[39] = c.op4[0];
    v[40 +: 2] = 2'(c.rsc);  v[42 +: 2] = 2'(c.asc);
    v[44] = c.rbias[0]; v[45] = c.abias[0];
    v[46 +: 2] = 2'(c.rdst); v[48 +: 2] = 2'(c.adst);
    return v;
  endfunction

  function automatic int mapv(int x, int m);
    int t;
    case (m)
      0: t = x;
      1: t = ONE - x;
      2: t = 2 * x - ONE;
      default: t = -x;
    endcase
    if (t > ONE) t = ONE;
    if (t < -ONE) t = -ONE;
    return t;
  endfunction

  function automatic int sbv(int x, int sc, int b);
    int y = x - (b != 0 ? ONE / 2 : 0);
    case (sc)
      0: y = y;
      1: y = y * 2;
      2: y = y * 4;
      default: y = y >>> 1;
    endcase
    if (y > ONE) y = ONE;
    if (y < -ONE) y = -ONE;
    return y;
  endfunction

  function automatic bundle_t ref_out(tcfg_t c, bundle_t r);
    bundle_t o = r;
    int a [4][3];
    int x [4];
    int ab [3], cd [3], d, m, aab, acd;
    bit neg = r[0][3] < 0;
    for (int k = 0; k < 4; k++) begin
      for (int ch = 0; ch < 3; ch++) a[k][ch] = mapv(r[c.rsel[k]][ch], c.rmap[k]);
      x[k] = mapv(r[c.asel[k]][c.ablue[k] != 0 ? 2 : 3], c.amap[k]);
    end
    d = a[0][0]*a[1][0] + a[0][1]*a[1][1] + a[0][2]*a[1][2];
    for (int ch = 0; ch < 3; ch++) ab[ch] = c.op1 != 0 ? (d >>> 8) : ((a[0][ch]*a[1][ch]) >>> 8);
    d = a[2][0]*a[3][0] + a[2][1]*a[3][1] + a[2][2]*a[3][2];
    for (int ch = 0; ch < 3; ch++) cd[ch] = c.op2 != 0 ? (d >>> 8) : ((a[2][ch]*a[3][ch]) >>> 8);
    for (int ch = 0; ch < 3; ch++) begin
      m = c.op3 != 0 ? (neg ? cd[ch] : ab[ch]) : ab[ch] + cd[ch];
      o[c.rdst][ch] = sbv(m, c.rsc, c.rbias);
    end
    aab = (x[0]*x[1]) >>> 8;
    acd = (x[2]*x[3]) >>> 8;
    m = c.op4 != 0 ? (neg ? acd : aab) : aab + acd;
    o[c.adst][3] = sbv(m, c.asc, c.abias);
    return o;
  endfunction

  function automatic int rnd_ch();
    return int'($urandom_range(1023)) - 512;
  endfunction

  function automatic bundle_t rnd_regs();
    bundle_t r;
    for (int i = 0; i < 4; i++)
      for (int c = 0; c < 4; c++) r[i][c] = rnd_ch();
    return r;
  endfunction

  function automatic tcfg_t rnd_cfg();
    tcfg_t c;
    for (int k = 0; k < 4; k++) begin
      c.rsel[k] = $urandom_range(3); c.rmap[k] = $urandom_range(3);
      c.asel[k] = $urandom_range(3); c.amap[k] = $urandom_range(3);
      c.ablue[k] = $urandom_range(1);
    end
    c.op1 = $urandom_range(1); c.op2 = $urandom_range(1);
    c.op3 = $urandom_range(1); c.op4 = $urandom_range(1);
    c.rsc = $urandom_range(3); c.asc = $urandom_range(3);
    c.rbias = $urandom_range(1); c.abias = $urandom_range(1);
    c.rdst = $urandom_range(3); c.adst = $urandom_range(3);
    return c;
  endfunction

  // A=reg1, B=reg3, C=reg2, D=reg3, identity maps, multiply, sum, x1, no bias
  function automatic tcfg_t base_cfg();
    tcfg_t c;
    int s [4] = '{1, 3, 2, 3};
    for (int k = 0; k < 4; k++) begin
      c.rsel[k] = s[k]; c.rmap[k] = 0;
      c.asel[k] = s[k]; c.amap[k] = 0; c.ablue[k] = 0;
    end
    c.op1 = 0; c.op2 = 0; c.op3 = 0; c.op4 = 0;
    c.rsc = 0; c.asc = 0; c.rbias = 0; c.abias = 0;
    c.rdst = 2; c.adst = 2;
    return c;
  endfunction

  // reference pipeline state
  bit      m1v = 0, m2v = 0, pend = 0, rand_ready = 0;
  bundle_t m1d, m2d, cur_r;
  string   m1t = "", m2t = "", cur_tag = "";
  tcfg_t   cur_c;

  task automatic chk_bit(string tag, string what, logic act, logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic chk_bus(string tag, logic [BUS_W-1:0] act, logic [BUS_W-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s regs_o actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    bit s1r, s2r, acc;
    @(negedge clk);
    ready_i = rand_ready ? ($urandom_range(9) < 5) : 1'b1;
    if (pend) begin
      valid_i = 1'b1;
      cfg_i   = pack_cfg(cur_c);
      regs_i  = pack_regs(cur_r);
    end else begin
      valid_i = 1'b0;
      cfg_i   = CFG_W'({$urandom, $urandom});
      regs_i  = {5{$urandom}};
    end
    #1;
    chk_bit("R9", "valid_o", valid_o, m2v);
    chk_bit("R10", "ready_o", ready_o, !m1v || !m2v || ready_i);
    if (m2v) chk_bus(m2t, regs_o, pack_regs(m2d));
    s2r = !m2v || ready_i;
    s1r = !m1v || s2r;
    acc = valid_i && s1r;
    if (s2r) begin m2v = m1v; m2d = m1d; m2t = m1t; end
    if (s1r) begin
      m1v = valid_i;
      if (acc) begin
        m1d  = ref_out(cur_c, cur_r);
        m1t  = cur_tag;
        pend = 0;
      end
    end
  endtask

  task automatic send(tcfg_t c, bundle_t r, string tag);
    cur_c = c; cur_r = r; cur_tag = tag; pend = 1;
    while (pend) tick();
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    tcfg_t   c;
    bundle_t r;
    int      xs [5] = '{-512, -200, 0, 130, 511};
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    chk_bit("R1", "valid_o", valid_o, 1'b0);
    chk_bit("R1", "ready_o", ready_o, 1'b1);
    tick();

    // R3: every map code on edge inputs, read back through AB with B=+1
    for (int m = 0; m < 4; m++)
      for (int i = 0; i < 5; i++) begin
        r = '{default: '{default: 0}};
        for (int ch = 0; ch < 4; ch++) begin r[3][ch] = ONE; r[1][ch] = xs[i]; end
        r[0][3] = 100;
        c = base_cfg();
        c.rmap[0] = m; c.amap[0] = m;
        c.op3 = 1; c.op4 = 1;
        send(c, r, "R3");
      end

    // R4: per-channel product versus dot product
    for (int i = 0; i < 8; i++) begin
      c = base_cfg();
      c.rsel[1] = 1; c.rsel[3] = 0;
      c.op1 = i & 1; c.op2 = (i >> 1) & 1;
      send(c, rnd_regs(), "R4");
    end

    // R5: mux on spare alpha sign, and sum
    for (int i = 0; i < 6; i++) begin
      r = rnd_regs();
      r[0][3] = (i % 3 == 0) ? -5 : (i % 3 == 1) ? 5 : -512;
      c = rnd_cfg();
      c.op3 = (i < 3); c.op4 = (i < 3);
      send(c, r, "R5");
    end

    // R6: alpha from blue or alpha channels
    for (int i = 0; i < 6; i++) begin
      c = rnd_cfg();
      for (int k = 0; k < 4; k++) c.ablue[k] = (i >> (k % 2)) & 1;
      send(c, rnd_regs(), "R6");
    end

    // R7: each scale code with and without bias, including saturation
    for (int sc = 0; sc < 4; sc++)
      for (int b = 0; b < 2; b++)
        for (int j = 0; j < 2; j++) begin
          c = rnd_cfg();
          c.rsc = sc; c.asc = sc; c.rbias = b; c.abias = b;
          if (j == 0) begin c.rmap[0] = 2; c.amap[0] = 2; c.op3 = 0; c.op4 = 0; end
          send(c, rnd_regs(), "R7");
        end

    // R8: every pairing of color and alpha destinations
    for (int d = 0; d < 16; d++) begin
      c = rnd_cfg();
      c.rdst = d & 3; c.adst = d >> 2;
      send(c, rnd_regs(), "R8");
    end

    // R2: untouched channels pass through
    for (int i = 0; i < 6; i++) send(rnd_cfg(), rnd_regs(), "R2");

    // R10: backpressure, idle gaps with garbage configuration
    rand_ready = 1;
    for (int i = 0; i < 300; i++) begin
      send(rnd_cfg(), rnd_regs(), "R10");
      repeat ($urandom_range(2)) tick();
    end
    rand_ready = 0;
    repeat (6) tick();

    summary();
    $finish;
  end
endmodule